// File: doc/BRIEF.md
# Operand Forwarding Select Logic

This block decides, for a five-stage in-order pipeline, where each operand of the instruction now in execute should come from, and where the store data of the instruction now in the memory stage should come from. It looks at the destination registers of the two older instructions sitting in the memory and writeback stages and picks, per operand, the youngest producer that has already computed the value. The block also contains the operand multiplexers, so its outputs are the operand values that the ALU and the data memory actually consume.

Each ALU input has its own selector with three sources: the memory-stage result, the writeback value, or the value read from the register file. The store-data input of the data memory has a second, narrower path: the value captured when the store left execute, or the writeback value when the instruction just ahead of the store writes the register being stored. A typical case is a load directly followed by a store of the loaded register. The block is purely combinational: a producer and its consumer are linked in the same cycle in which they occupy the two stages. Stall generation sits outside. The surrounding interlock guarantees that no execute instruction needs the result of a load that is still in the memory stage.

Top module: `operand_bypass_top`

## Requirements
- R1: When the memory-stage instruction writes a register (write-enable high, destination non-zero, not a load) equal to execute source 1, select code 0 is output on the A select and the A operand equals the memory-stage result.
- R2: When no memory-stage match exists for source 1 but the writeback instruction writes that register (write-enable high, destination non-zero), select code 1 is output and the A operand equals the writeback value.
- R3: With neither match, select code 2 is output and the A operand equals the register-file value; code 3 never appears.
- R4: The B operand applies the same three rules to execute source 2, independently of the A operand.
- R5: When both the memory and writeback stages match the same source, the memory stage wins (code 0).
- R6: Register 0 is never forwarded, on any of the three paths, whatever the producers' write-enables.
- R7: A producer whose write-enable is low is never a forwarding source.
- R8: A load in the memory stage is never a source for the ALU operands; selection falls through to writeback or the register file.
- R9: When the memory-stage instruction is a store whose data register equals the writeback destination (write-enable high, non-zero), the store-data select is 1 and the store data equals the writeback value; otherwise the select is 0 and the store data equals the value captured from execute. Only the data register is compared, so a writeback to any other register (such as the address base) leaves the store data untouched.
- R10: When the memory-stage instruction is not a store, the store-data select is 0 and the captured value passes through.
- R11: All selects and operand values follow the stage inputs within the same cycle, with no register on the path.
- R12: Over a stream of mixed ALU, load, store and empty slots, every operand delivered equals the value a strictly sequential execution of the same stream would read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_rs1_i | input | 5 | Execute-stage source register 1 |
| x_rs2_i | input | 5 | Execute-stage source register 2 |
| x_rf1_i | input | 32 | Register-file value read for source 1 |
| x_rf2_i | input | 32 | Register-file value read for source 2 |
| m_rd_i | input | 5 | Memory-stage destination register |
| m_wen_i | input | 1 | Memory-stage instruction writes a register |
| m_load_i | input | 1 | Memory-stage instruction is a load |
| m_res_i | input | 32 | Memory-stage ALU result |
| m_store_i | input | 1 | Memory-stage instruction is a store |
| m_st_rs_i | input | 5 | Data register of the memory-stage store |
| m_st_data_i | input | 32 | Store data captured when the store left execute |
| w_rd_i | input | 5 | Writeback destination register |
| w_wen_i | input | 1 | Writeback instruction writes a register |
| w_val_i | input | 32 | Writeback value |
| fwd_a_sel_o | output | 2 | A select: 0 memory stage, 1 writeback, 2 register file |
| fwd_b_sel_o | output | 2 | B select, same encoding |
| st_sel_o | output | 1 | Store-data select: 0 captured value, 1 writeback |
| alu_a_o | output | 32 | Selected ALU operand A |
| alu_b_o | output | 32 | Selected ALU operand B |
| st_data_o | output | 32 | Selected store data |

## Verification
Directed patterns place a single producer in one stage to separate the three sources, then both producers on one register to show the memory stage wins, and then disqualified producers (register 0, write-enable low, load in memory) to show the selection falls through to the next source and not to a wrong one. Store cases contrast a writeback to the data register with a writeback to another register, and a store with a non-store carrying the same register field. A generated stream with only eight registers in use produces back-to-back, one-apart and two-apart dependences, including a load followed by a store of the loaded register. It is compared with a sequential model of the same stream, which tells apart a missing path, a wrong priority, and a path taken from the wrong stage.

// File: rtl/byp_pkg.sv
package byp_pkg;

    // Select code driven onto each ALU operand multiplexer.
    typedef enum logic [1:0] {
        FWD_MEM = 2'd0,   // memory-stage result
        FWD_WB  = 2'd1,   // writeback value
        FWD_RF  = 2'd2    // register-file value
    } fwd_sel_e;

    // Select code for the data-memory store-data input.
    typedef enum logic {
        STD_PIPE = 1'b0,  // value captured when the store left execute
        STD_WB   = 1'b1   // writeback value
    } std_sel_e;

    // Number of ALU operand multiplexers (A and B).
    localparam int unsigned NUM_ALU_OPND = 2;

    // A producer may feed a bypass only if it writes a real register
    // and is not excluded by the caller (load in memory, non-store, ...).
    function automatic logic producer_ok(input logic wen,
                                         input logic dst_is_zero,
                                         input logic excluded);
        return wen && !dst_is_zero && !excluded;
    endfunction

endpackage

// File: rtl/byp_match.sv
module byp_match
    import byp_pkg::*;
#(
    parameter int unsigned RIDX = 5
) (
    input  logic [RIDX-1:0] src_i,
    input  logic [RIDX-1:0] dst_i,
    input  logic            wen_i,
    input  logic            excl_i,
    output logic            hit_o
);

    logic dst_zero;
    logic same_reg;

    assign dst_zero = (dst_i == '0);
    assign same_reg = (src_i == dst_i);
    assign hit_o    = producer_ok(wen_i, dst_zero, excl_i) && same_reg;

    // Register 0 must never produce a hit on any path.
    always_comb begin
        if (src_i == '0) begin
            AST_R0_NEVER_HITS: assert (!hit_o); // R6
        end
    end

    // A producer that writes nothing must never produce a hit.
    always_comb begin
        if (!wen_i) begin
            AST_NO_WEN_NO_HIT: assert (!hit_o); // R7
        end
    end

endmodule

// File: rtl/byp_opnd_sel.sv
module byp_opnd_sel
    import byp_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned RIDX = 5
) (
    input  logic [RIDX-1:0] src_i,
    input  logic [XLEN-1:0] rf_val_i,
    input  logic [RIDX-1:0] m_rd_i,
    input  logic            m_wen_i,
    input  logic            m_load_i,
    input  logic [XLEN-1:0] m_res_i,
    input  logic [RIDX-1:0] w_rd_i,
    input  logic            w_wen_i,
    input  logic [XLEN-1:0] w_val_i,
    output fwd_sel_e        sel_o,
    output logic [XLEN-1:0] val_o
);

    logic hit_mem;
    logic hit_wb;

    // Memory stage: a load's result there is only an address, never data.
    byp_match #(.RIDX(RIDX)) u_mem_match (
        .src_i  (src_i),
        .dst_i  (m_rd_i),
        .wen_i  (m_wen_i),
        .excl_i (m_load_i),
        .hit_o  (hit_mem)
    );

    // Writeback stage: every writing instruction qualifies.
    byp_match #(.RIDX(RIDX)) u_wb_match (
        .src_i  (src_i),
        .dst_i  (w_rd_i),
        .wen_i  (w_wen_i),
        .excl_i (1'b0),
        .hit_o  (hit_wb)
    );

    // Fixed priority: the younger producer (memory stage) wins.
    always_comb begin
        if (hit_mem) begin
            sel_o = FWD_MEM;
        end else if (hit_wb) begin
            sel_o = FWD_WB;
        end else begin
            sel_o = FWD_RF;
        end
    end

    // Operand multiplexer driven by the select code.
    always_comb begin
        unique case (sel_o)
            FWD_MEM: val_o = m_res_i;
            FWD_WB:  val_o = w_val_i;
            default: val_o = rf_val_i;
        endcase
    end

    always_comb begin
        AST_SEL_LEGAL: assert (sel_o != fwd_sel_e'(2'd3)); // R3
        if (hit_mem && hit_wb) begin
            AST_MEM_OVER_WB: assert (sel_o == FWD_MEM); // R5
        end
        if (sel_o == FWD_MEM) begin
            AST_MUX_MEM_VALUE: assert (val_o == m_res_i); // R1
        end
        if (sel_o == FWD_WB) begin
            AST_MUX_WB_VALUE: assert (val_o == w_val_i); // R2
        end
    end

endmodule

// File: rtl/byp_store_sel.sv
module byp_store_sel
    import byp_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned RIDX = 5
) (
    input  logic            m_store_i,
    input  logic [RIDX-1:0] m_st_rs_i,
    input  logic [XLEN-1:0] m_st_data_i,
    input  logic [RIDX-1:0] w_rd_i,
    input  logic            w_wen_i,
    input  logic [XLEN-1:0] w_val_i,
    output std_sel_e        sel_o,
    output logic [XLEN-1:0] data_o
);

    logic hit_wb;

    // Only the store's data register is compared; the address was
    // formed in execute and has no path through this block.
    byp_match #(.RIDX(RIDX)) u_wb_match (
        .src_i  (m_st_rs_i),
        .dst_i  (w_rd_i),
        .wen_i  (w_wen_i),
        .excl_i (!m_store_i),
        .hit_o  (hit_wb)
    );

    assign sel_o  = hit_wb ? STD_WB : STD_PIPE;
    assign data_o = (sel_o == STD_WB) ? w_val_i : m_st_data_i;

    always_comb begin
        if (!m_store_i) begin
            AST_ONLY_STORES_FWD: assert (sel_o == STD_PIPE); // R10
        end
        if (sel_o == STD_WB) begin
            AST_STDATA_FROM_WB: assert (data_o == w_val_i); // R9
        end else begin
            AST_STDATA_FROM_PIPE: assert (data_o == m_st_data_i); // R9
        end
    end

endmodule

// File: rtl/operand_bypass_top.sv
module operand_bypass_top
    import byp_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned RIDX    = $clog2(NUM_REGS)
) (
    input  logic [RIDX-1:0] x_rs1_i,
    input  logic [RIDX-1:0] x_rs2_i,
    input  logic [XLEN-1:0] x_rf1_i,
    input  logic [XLEN-1:0] x_rf2_i,
    input  logic [RIDX-1:0] m_rd_i,
    input  logic            m_wen_i,
    input  logic            m_load_i,
    input  logic [XLEN-1:0] m_res_i,
    input  logic            m_store_i,
    input  logic [RIDX-1:0] m_st_rs_i,
    input  logic [XLEN-1:0] m_st_data_i,
    input  logic [RIDX-1:0] w_rd_i,
    input  logic            w_wen_i,
    input  logic [XLEN-1:0] w_val_i,
    output logic [1:0]      fwd_a_sel_o,
    output logic [1:0]      fwd_b_sel_o,
    output logic            st_sel_o,
    output logic [XLEN-1:0] alu_a_o,
    output logic [XLEN-1:0] alu_b_o,
    output logic [XLEN-1:0] st_data_o
);

    // Per-operand views of the execute-stage sources.
    logic [RIDX-1:0] opnd_src [NUM_ALU_OPND];
    logic [XLEN-1:0] opnd_rf  [NUM_ALU_OPND];
    fwd_sel_e        opnd_sel [NUM_ALU_OPND];
    logic [XLEN-1:0] opnd_val [NUM_ALU_OPND];
    std_sel_e        st_sel;

    assign opnd_src[0] = x_rs1_i;
    assign opnd_src[1] = x_rs2_i;
    assign opnd_rf[0]  = x_rf1_i;
    assign opnd_rf[1]  = x_rf2_i;

    // One independent selector and multiplexer per ALU input.
    for (genvar g = 0; g < NUM_ALU_OPND; g++) begin : g_opnd
        byp_opnd_sel #(.XLEN(XLEN), .RIDX(RIDX)) u_sel (
            .src_i    (opnd_src[g]),
            .rf_val_i (opnd_rf[g]),
            .m_rd_i   (m_rd_i),
            .m_wen_i  (m_wen_i),
            .m_load_i (m_load_i),
            .m_res_i  (m_res_i),
            .w_rd_i   (w_rd_i),
            .w_wen_i  (w_wen_i),
            .w_val_i  (w_val_i),
            .sel_o    (opnd_sel[g]),
            .val_o    (opnd_val[g])
        );
    end

    // Writeback-to-memory path, store data only.
    byp_store_sel #(.XLEN(XLEN), .RIDX(RIDX)) u_store (
        .m_store_i   (m_store_i),
        .m_st_rs_i   (m_st_rs_i),
        .m_st_data_i (m_st_data_i),
        .w_rd_i      (w_rd_i),
        .w_wen_i     (w_wen_i),
        .w_val_i     (w_val_i),
        .sel_o       (st_sel),
        .data_o      (st_data_o)
    );

    assign fwd_a_sel_o = opnd_sel[0];
    assign fwd_b_sel_o = opnd_sel[1];
    assign alu_a_o     = opnd_val[0];
    assign alu_b_o     = opnd_val[1];
    assign st_sel_o    = st_sel;

    // A load in the memory stage holds an address, never a data source.
    always_comb begin
        if (m_load_i) begin
            AST_LOAD_NEVER_SOURCE: assert (fwd_a_sel_o != 2'd0 && fwd_b_sel_o != 2'd0); // R8
        end
    end

    // With no writing producer at all, both operands come from the register file.
    always_comb begin
        if (!m_wen_i && !w_wen_i) begin
            AST_IDLE_USES_RF: assert (alu_a_o == x_rf1_i && alu_b_o == x_rf2_i); // R3
        end
    end

endmodule

// File: tb/operand_bypass_top_tb_top.sv
`timescale 1ns/1ps
module operand_bypass_top_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [4:0]  x_rs1 = '0, x_rs2 = '0, m_rd = '0, m_st_rs = '0, w_rd = '0;
    logic [31:0] x_rf1 = '0, x_rf2 = '0, m_res = '0, m_st_data = '0, w_val = '0;
    logic        m_wen = 1'b0, m_load = 1'b0, m_store = 1'b0, w_wen = 1'b0;
    logic [1:0]  a_sel, b_sel;
    logic        s_sel;
    logic [31:0] alu_a, alu_b, st_data;

    operand_bypass_top dut_i (
        .x_rs1_i(x_rs1), .x_rs2_i(x_rs2), .x_rf1_i(x_rf1), .x_rf2_i(x_rf2),
        .m_rd_i(m_rd), .m_wen_i(m_wen), .m_load_i(m_load), .m_res_i(m_res),
        .m_store_i(m_store), .m_st_rs_i(m_st_rs), .m_st_data_i(m_st_data),
        .w_rd_i(w_rd), .w_wen_i(w_wen), .w_val_i(w_val),
        .fwd_a_sel_o(a_sel), .fwd_b_sel_o(b_sel), .st_sel_o(s_sel),
        .alu_a_o(alu_a), .alu_b_o(alu_b), .st_data_o(st_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [31:0] RF1 = 32'h1111_0001, RF2 = 32'h2222_0002;
    localparam logic [31:0] MRES = 32'hAAAA_0003, WVAL = 32'hBBBB_0004, SDAT = 32'hCCCC_0005;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Quiet pipeline with distinct values on every data input.
    task automatic idle();
        x_rs1 = '0; x_rs2 = '0; x_rf1 = RF1; x_rf2 = RF2;
        m_rd = '0; m_wen = 0; m_load = 0; m_res = MRES; m_store = 0;
        m_st_rs = '0; m_st_data = SDAT; w_rd = '0; w_wen = 0; w_val = WVAL;
    endtask

    task automatic t_idle();
        @(negedge clk); idle(); x_rs1 = 5'd5; x_rs2 = 5'd6; #1;
        chk("R3", "a_sel idle", 32'(a_sel), 32'd2);
        chk("R3", "alu_a idle", alu_a, RF1);
        chk("R3", "b_sel idle", 32'(b_sel), 32'd2);
        chk("R10", "st_sel idle", 32'(s_sel), 32'd0);
        chk("R10", "st_data idle", st_data, SDAT);
    endtask

    task automatic t_mem_to_a();
        @(negedge clk); idle();
        m_rd = 5'd5; m_wen = 1; x_rs1 = 5'd5; x_rs2 = 5'd6; #1;
        chk("R1", "a_sel mem", 32'(a_sel), 32'd0);
        chk("R1", "alu_a mem", alu_a, MRES);
        chk("R4", "b_sel unaffected", 32'(b_sel), 32'd2);
        chk("R4", "alu_b unaffected", alu_b, RF2);
    endtask

    task automatic t_wb_to_b();
        @(negedge clk); idle();
        w_rd = 5'd7; w_wen = 1; x_rs1 = 5'd3; x_rs2 = 5'd7; #1;
        chk("R2", "b_sel wb", 32'(b_sel), 32'd1);
        chk("R4", "alu_b wb", alu_b, WVAL);
        chk("R3", "a_sel rf", 32'(a_sel), 32'd2);
        // A also from writeback: R2 on operand A
        x_rs1 = 5'd7; #1;
        chk("R2", "a_sel wb", 32'(a_sel), 32'd1);
        chk("R2", "alu_a wb", alu_a, WVAL);
    endtask

    task automatic t_priority();
        @(negedge clk); idle();
        m_rd = 5'd3; m_wen = 1; w_rd = 5'd3; w_wen = 1; x_rs1 = 5'd3; x_rs2 = 5'd3; #1;
        chk("R5", "a_sel both", 32'(a_sel), 32'd0);
        chk("R5", "alu_a both", alu_a, MRES);
        chk("R5", "b_sel both", 32'(b_sel), 32'd0);
        chk("R5", "alu_b both", alu_b, MRES);
    endtask

    task automatic t_reg_zero();
        @(negedge clk); idle();
        m_rd = 5'd0; m_wen = 1; w_rd = 5'd0; w_wen = 1; x_rs1 = 5'd0; x_rs2 = 5'd0;
        m_store = 1; m_st_rs = 5'd0; #1;
        chk("R6", "a_sel r0", 32'(a_sel), 32'd2);
        chk("R6", "alu_b r0", alu_b, RF2);
        chk("R6", "st_sel r0", 32'(s_sel), 32'd0);
        chk("R6", "st_data r0", st_data, SDAT);
    endtask

    task automatic t_wen_low();
        @(negedge clk); idle();
        m_rd = 5'd4; m_wen = 0; w_rd = 5'd4; w_wen = 1; x_rs1 = 5'd4; #1;
        chk("R7", "a_sel mem wen low", 32'(a_sel), 32'd1);
        chk("R7", "alu_a mem wen low", alu_a, WVAL);
        w_wen = 0; #1;
        chk("R7", "a_sel both wen low", 32'(a_sel), 32'd2);
        chk("R7", "alu_a both wen low", alu_a, RF1);
    endtask

    task automatic t_load_in_mem();
        @(negedge clk); idle();
        m_rd = 5'd9; m_wen = 1; m_load = 1; x_rs1 = 5'd9; x_rs2 = 5'd9; #1;
        chk("R8", "a_sel load", 32'(a_sel), 32'd2);
        chk("R8", "alu_b load", alu_b, RF2);
        w_rd = 5'd9; w_wen = 1; #1;
        chk("R8", "b_sel load+wb", 32'(b_sel), 32'd1);
        chk("R8", "alu_a load+wb", alu_a, WVAL);
    endtask

    task automatic t_store_wb();
        @(negedge clk); idle();
        m_store = 1; m_st_rs = 5'd4; w_rd = 5'd4; w_wen = 1; #1;
        chk("R9", "st_sel match", 32'(s_sel), 32'd1);
        chk("R9", "st_data match", st_data, WVAL);
        w_rd = 5'd5; #1;   // writeback to another register (e.g. the base)
        chk("R9", "st_sel other reg", 32'(s_sel), 32'd0);
        chk("R9", "st_data other reg", st_data, SDAT);
        w_rd = 5'd4; w_wen = 0; #1;
        chk("R9", "st_sel wen low", 32'(s_sel), 32'd0);
    endtask

    task automatic t_non_store();
        @(negedge clk); idle();
        m_store = 0; m_st_rs = 5'd4; w_rd = 5'd4; w_wen = 1; #1;
        chk("R10", "st_sel non-store", 32'(s_sel), 32'd0);
        chk("R10", "st_data non-store", st_data, SDAT);
    endtask

    // Change stage inputs mid-cycle; outputs must track before the next edge.
    task automatic t_same_cycle();
        @(negedge clk); idle();
        m_rd = 5'd2; m_wen = 1; x_rs1 = 5'd2; #1;
        chk("R11", "alu_a first", alu_a, MRES);
        m_res = 32'h0BAD_F00D; #0.5;
        chk("R11", "alu_a follows", alu_a, 32'h0BAD_F00D);
        m_rd = 5'd3; #0.5;
        chk("R11", "a_sel follows", 32'(a_sel), 32'd2);
    endtask

    // ---- Stream against a sequential model (R12) ----
    typedef struct {
        int          op;     // 0 empty, 1 ALU, 2 load, 3 store
        int          rd, rs1, rs2;
        logic [31:0] a, b, res, ldv, std;
    } slot_t;

    logic [31:0] lfsr = 32'h1357_9BDF;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
        return t;
    endfunction

    function automatic bit writes(input slot_t s);
        return s.op == 1 || s.op == 2;
    endfunction

    task automatic t_stream(input int cycles);
        logic [31:0] spec [8];
        logic [31:0] comm [8];
        slot_t sx, sm, sw, nw;
        for (int i = 0; i < 8; i++) begin
            spec[i] = 32'(i) * 32'h0101_0101;
            comm[i] = spec[i];
        end
        spec[0] = '0; comm[0] = '0;
        sx = '{op: 0, rd: 0, rs1: 0, rs2: 0, a: 0, b: 0, res: 0, ldv: 0, std: 0};
        sm = sx; sw = sx;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            // retire writeback into the register file
            if (writes(sw) && sw.rd != 0) comm[sw.rd] = (sw.op == 2) ? sw.ldv : sw.res;
            sw = sm; sm = sx;
            // issue a new instruction into execute
            lfsr = nxt(lfsr);
            nw.op = (lfsr[3:0] < 6) ? 1 : (lfsr[3:0] < 10) ? 2 : (lfsr[3:0] < 13) ? 3 : 0;
            nw.rd = int'(lfsr[6:4]); nw.rs1 = int'(lfsr[9:7]); nw.rs2 = int'(lfsr[12:10]);
            if (sm.op == 2 && sm.rd != 0) begin   // interlock keeps load-use apart
                if (nw.rs1 == sm.rd) nw.rs1 = sm.rd ^ 1;
                if (nw.op != 3 && nw.rs2 == sm.rd) nw.rs2 = sm.rd ^ 1;
            end
            nw.a = spec[nw.rs1]; nw.b = spec[nw.rs2];
            nw.res = (nw.op == 1) ? nw.a + nw.b + 32'd1 : nw.a + 32'd4;
            nw.ldv = nw.res * 32'd3 + 32'd7;
            nw.std = '0;
            if (nw.op == 1 && nw.rd != 0) spec[nw.rd] = nw.res;
            if (nw.op == 2 && nw.rd != 0) spec[nw.rd] = nw.ldv;
            sx = nw;
            // drive the stage fields
            x_rs1 = 5'(sx.rs1); x_rs2 = 5'(sx.rs2);
            x_rf1 = comm[sx.rs1]; x_rf2 = comm[sx.rs2];
            m_rd = 5'(sm.rd); m_wen = writes(sm); m_load = (sm.op == 2);
            m_res = sm.res; m_store = (sm.op == 3); m_st_rs = 5'(sm.rs2); m_st_data = sm.std;
            w_rd = 5'(sw.rd); w_wen = writes(sw);
            w_val = (sw.op == 2) ? sw.ldv : sw.res;
            #1;
            if (sx.op != 0) chk("R12", "stream alu_a", alu_a, sx.a);
            if (sx.op == 1) chk("R12", "stream alu_b", alu_b, sx.b);
            if (sm.op == 3) chk("R12", "stream st_data", st_data, sm.b);
            sx.std = alu_b;   // latched into the memory-stage register
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_idle();
        t_mem_to_a();
        t_wb_to_b();
        t_priority();
        t_reg_zero();
        t_wen_low();
        t_load_in_mem();
        t_store_wb();
        t_non_store();
        t_same_cycle();
        t_stream(400);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule